// File: doc/BRIEF.md
# Multiplexed LCD Segment Buffer Controller

This block feeds the digital side of a segment LCD driver. A CPU writes 4-bit nibbles, one for each segment line, into a 32-entry shadow buffer. Writes go through an address pointer that steps down by one after every write. A separate strobe loads the pointer with any entry index. Each nibble bit belongs to one backplane phase: bit p is the segment's ON/OFF value while common phase p is active. A value of 1 means ON. The buffer holds raw segment bits and the block does no character decoding.

A scan sequencer steps through the common phases. At 1/4 duty it visits phases 0 to 3; at 1/3 duty it visits phases 0 to 2. Each phase lasts a programmable number of clocks, counted from the enabled slow clock. For every phase the block outputs the phase index and 32 segment bits. A frame toggle changes at the end of each complete scan, so the analog stage can swap polarity and keep the drive DC-free.

The scan side reads a display copy of the shadow buffer. That copy is refreshed only when a frame starts, so a half-finished CPU update never shows on the glass. A blanking input turns all segments off and leaves both buffers unchanged. Power save parks the sequencer in an idle state.

Top module: `lcdseg_ctrl`

## Requirements
- R1: After reset the pointer selects entry 31. A write pulse stores `wr_nib_i` in the selected shadow entry, and the pointer then selects the next lower entry.
- R2: A write at entry 0 leaves the pointer selecting entry 31.
- R3: `set_ptr_i` loads the pointer from `ptr_val_i`. If a write occurs in the same cycle, the nibble goes to the entry selected before the load.
- R4: While phase p is active and not blanked, bit k of `seg_o` equals bit p of display entry k (1 = ON).
- R5: With `duty4_i`=1 the phases run 0,1,2,3,0. With `duty4_i`=0 they run 0,1,2,0. A phase index at or above the last one wraps to 0 at its next step.
- R6: While `scan_en_i` is high, each phase lasts `frame_div_i`+1 clocks. While `scan_en_i` is low, the phase and its dwell count hold.
- R7: `frame_tgl_o` inverts on the same edge where the phase wraps from the last phase to 0, and at no other time.
- R8: `blank_i` forces `seg_o` to all zero in the same cycle. The buffer contents are kept and reappear when blanking ends.
- R9: `psave_i` high makes the block idle from the next edge: `com_valid_o`=0, `com_idx_o`=0, `seg_o`=0. When `psave_i` drops, phase 0 starts on the next edge with a fresh dwell count. This restart does not change the toggle.
- R10: The display copy takes the whole shadow buffer on each edge that starts phase 0: a wrap or a restart from idle. A write on that same edge lands in the shadow buffer only.
- R11: Asynchronous reset clears both buffers, the toggle and the dwell count, and leaves the sequencer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 1 | Write pulse for one nibble |
| wr_nib_i | input | 4 | Nibble to write |
| set_ptr_i | input | 1 | Load the pointer |
| ptr_val_i | input | 5 | New pointer value |
| duty4_i | input | 1 | 1 = 1/4 duty, 0 = 1/3 duty |
| blank_i | input | 1 | Force all segments OFF |
| psave_i | input | 1 | Power save, sequencer idle |
| scan_en_i | input | 1 | Slow-clock enable for the dwell counter |
| frame_div_i | input | 8 | Dwell length minus one, in enabled clocks |
| com_valid_o | output | 1 | A common phase is active |
| com_idx_o | output | 2 | Active phase index |
| seg_o | output | 32 | Segment ON bits for the active phase |
| frame_tgl_o | output | 1 | Inverts at each full scan |

## Verification
A pointer that goes wrong writes a nibble into the wrong entry. That error shows on `seg_o` at the start of the next frame, in the phase of whichever nibble bit is set. A dwell or duty fault shows on `com_idx_o` within one phase length. A display copy loaded at the wrong time shows as segment bits changing in the middle of a frame. The bench keeps a cycle model of the pointer, both buffers and the sequencer. It compares every output on every cycle, so any such divergence is reported on the cycle it first reaches a port.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  localparam int unsigned N_SEG = 32;
  localparam int unsigned N_COM = 4;
  localparam int unsigned PTR_W = $clog2(N_SEG);
  localparam int unsigned PH_W  = $clog2(N_COM);
  typedef logic [N_COM-1:0] nib_t;
endpackage

// File: rtl/lcdseg_buf.sv
module lcdseg_buf
  import lcdseg_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  nib_t                        nib_i,
  input  logic                        set_i,
  input  logic [PTR_W-1:0]            ptr_i,
  input  logic                        load_i,
  output logic [N_SEG-1:0][N_COM-1:0] disp_o
);
  logic [PTR_W-1:0] ptr_q;
  nib_t             sh_q [N_SEG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= PTR_W'(N_SEG - 1);
    else if (set_i) ptr_q <= ptr_i;
    else if (wr_i)  ptr_q <= (ptr_q == '0) ? PTR_W'(N_SEG - 1) : ptr_q - 1'b1;
  end

  for (genvar k = 0; k < N_SEG; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[k]   <= '0;
        disp_o[k] <= '0;
      end else begin
        if (wr_i && ptr_q == PTR_W'(k)) sh_q[k] <= nib_i;
        // display copy sees the shadow value from before this edge
        if (load_i) disp_o[k] <= sh_q[k];
      end
    end
  end
endmodule

// File: rtl/lcdseg_scan.sv
module lcdseg_scan
  import lcdseg_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  input  logic             psave_i,
  input  logic             duty4_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             valid_o,
  output logic [PH_W-1:0]  idx_o,
  output logic             tgl_o,
  output logic             load_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [PH_W-1:0]  last;
  logic             tick, wrap;

  assign last   = duty4_i ? PH_W'(N_COM - 1) : PH_W'(N_COM - 2);
  assign tick   = valid_o && scan_en_i && (cnt_q >= div_i);
  assign wrap   = tick && (idx_o >= last);
  assign load_o = !psave_i && (!valid_o || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      cnt_q   <= '0;
      tgl_o   <= 1'b0;
    end else if (psave_i) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      cnt_q   <= '0;
    end else if (!valid_o) begin
      valid_o <= 1'b1;
      idx_o   <= '0;
      cnt_q   <= '0;
    end else if (scan_en_i) begin
      if (tick) begin
        cnt_q <= '0;
        if (wrap) begin
          idx_o <= '0;
          tgl_o <= ~tgl_o;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdseg_ctrl.sv
module lcdseg_ctrl
  import lcdseg_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_data_i,
  input  logic [N_COM-1:0] wr_nib_i,
  input  logic             set_ptr_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  input  logic             duty4_i,
  input  logic             blank_i,
  input  logic             psave_i,
  input  logic             scan_en_i,
  input  logic [DIV_W-1:0] frame_div_i,
  output logic             com_valid_o,
  output logic [PH_W-1:0]  com_idx_o,
  output logic [N_SEG-1:0] seg_o,
  output logic             frame_tgl_o
);
  logic [N_SEG-1:0][N_COM-1:0] disp;
  logic                        load;

  lcdseg_buf u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_data_i),
    .nib_i  (wr_nib_i),
    .set_i  (set_ptr_i),
    .ptr_i  (ptr_val_i),
    .load_i (load),
    .disp_o (disp)
  );

  lcdseg_scan #(.DIV_W(DIV_W)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scan_en_i (scan_en_i),
    .psave_i   (psave_i),
    .duty4_i   (duty4_i),
    .div_i     (frame_div_i),
    .valid_o   (com_valid_o),
    .idx_o     (com_idx_o),
    .tgl_o     (frame_tgl_o),
    .load_o    (load)
  );

  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    assign seg_o[k] = com_valid_o && !blank_i && disp[k][com_idx_o];
  end
endmodule

// File: rtl/lcdseg_chk.sv
module lcdseg_chk
  import lcdseg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_i,
  input logic             psave_i,
  input logic             scan_en_i,
  input logic             com_valid_o,
  input logic [PH_W-1:0]  com_idx_o,
  input logic [N_SEG-1:0] seg_o,
  input logic             frame_tgl_o
);
  p_blank_dark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> seg_o == '0);

  p_psave_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psave_i |=> !com_valid_o && com_idx_o == '0);

  p_idle_dark_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_valid_o |-> seg_o == '0);

  p_tgl_at_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_tgl_o) |-> com_valid_o && com_idx_o == '0);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_valid_o && !scan_en_i && !psave_i) |=> $stable(com_idx_o));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_valid_o && $past(com_valid_o) && com_idx_o != $past(com_idx_o))
      |-> (com_idx_o == '0 || com_idx_o == PH_W'($past(com_idx_o) + 1'b1)));
endmodule

bind lcdseg_ctrl lcdseg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blank_i     (blank_i),
  .psave_i     (psave_i),
  .scan_en_i   (scan_en_i),
  .com_valid_o (com_valid_o),
  .com_idx_o   (com_idx_o),
  .seg_o       (seg_o),
  .frame_tgl_o (frame_tgl_o)
);

// File: tb/sim_lcdseg_ctrl.sv
module sim_lcdseg_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_data_i = 1'b0;
  logic [3:0]  wr_nib_i = '0;
  logic        set_ptr_i = 1'b0;
  logic [4:0]  ptr_val_i = '0;
  logic        duty4_i = 1'b1;
  logic        blank_i = 1'b0;
  logic        psave_i = 1'b1;
  logic        scan_en_i = 1'b1;
  logic [7:0]  frame_div_i = 8'd1;
  logic        com_valid_o;
  logic [1:0]  com_idx_o;
  logic [31:0] seg_o;
  logic        frame_tgl_o;

  int unsigned n_chk = 0, n_err = 0;
  string       cur_tag = "R1";

  // bench model
  logic [3:0] sh_m [32];
  logic [3:0] dp_m [32];
  logic [4:0] ptr_m;
  logic       val_m, tgl_m;
  logic [1:0] idx_m;
  int unsigned cnt_m;

  always #2.5 clk_i = ~clk_i;

  lcdseg_ctrl u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_seg();
    logic [31:0] s = '0;
    if (val_m && !blank_i)
      for (int k = 0; k < 32; k++) s[k] = dp_m[k][idx_m];
    return s;
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < 32; k++) begin sh_m[k] = '0; dp_m[k] = '0; end
    ptr_m = 5'd31; val_m = 0; tgl_m = 0; idx_m = 0; cnt_m = 0;
  endfunction

  // advance model by one edge using the inputs held across it
  function automatic void model_step();
    logic [1:0] last = duty4_i ? 2'd3 : 2'd2;
    bit tick = val_m && scan_en_i && (cnt_m >= frame_div_i);
    bit load = !psave_i && (!val_m || (tick && idx_m >= last));
    if (load) for (int k = 0; k < 32; k++) dp_m[k] = sh_m[k];
    if (wr_data_i) sh_m[ptr_m] = wr_nib_i;
    if (set_ptr_i) ptr_m = ptr_val_i;
    else if (wr_data_i) ptr_m = ptr_m - 5'd1;
    if (psave_i) begin val_m = 0; idx_m = 0; cnt_m = 0; end
    else if (!val_m) begin val_m = 1; idx_m = 0; cnt_m = 0; end
    else if (scan_en_i) begin
      if (tick) begin
        cnt_m = 0;
        if (idx_m >= last) begin idx_m = 0; tgl_m = ~tgl_m; end
        else idx_m = idx_m + 2'd1;
      end else cnt_m++;
    end
  endfunction

  task automatic compare();
    string st = blank_i ? "R8" : cur_tag;
    check(com_valid_o == val_m, "R9 valid", 32'(com_valid_o), 32'(val_m));
    check(com_idx_o == idx_m, scan_en_i ? "R5 idx" : "R6 idx", 32'(com_idx_o), 32'(idx_m));
    check(frame_tgl_o == tgl_m, "R7 tgl", 32'(frame_tgl_o), 32'(tgl_m));
    check(seg_o == exp_seg(), st, seg_o, exp_seg());
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    model_step();
    compare();
  endtask

  task automatic wr(input logic [3:0] n);
    wr_data_i = 1; wr_nib_i = n; cyc(); wr_data_i = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    void'($urandom(32'h5eed_1cd0));
    model_reset();
    #12;
    // R11 reset state
    check(!com_valid_o && com_idx_o == 0 && !frame_tgl_o && seg_o == 0, "R11 reset",
          {com_valid_o, frame_tgl_o, seg_o[29:0]}, 32'h0);
    @(negedge clk_i); rst_ni = 1;
    cur_tag = "R11"; run(3);

    cur_tag = "R1"; psave_i = 0;
    for (int k = 0; k < 32; k++) wr(4'($urandom));
    run(40);
    cur_tag = "R2";
    for (int k = 0; k < 3; k++) wr(4'($urandom));
    run(40);
    cur_tag = "R3";
    set_ptr_i = 1; ptr_val_i = 5'd7; wr(4'hF); set_ptr_i = 0;
    wr(4'h5); wr(4'hA);
    run(40);
    cur_tag = "R10"; frame_div_i = 8'd20;
    run(30);
    for (int k = 0; k < 6; k++) wr(4'($urandom));
    run(200);
    cur_tag = "R5"; duty4_i = 0; frame_div_i = 8'd2; run(80);
    duty4_i = 1; run(60);
    cur_tag = "R6"; scan_en_i = 0; run(30); scan_en_i = 1; run(20);
    cur_tag = "R8"; blank_i = 1; run(15); blank_i = 0; cur_tag = "R4"; run(20);
    cur_tag = "R9"; psave_i = 1; run(10); psave_i = 0; run(30);

    cur_tag = "R4";
    for (int i = 0; i < 5000; i++) begin
      wr_data_i = ($urandom % 4) == 0;
      wr_nib_i  = 4'($urandom);
      set_ptr_i = ($urandom % 32) == 0;
      ptr_val_i = 5'($urandom);
      scan_en_i = ($urandom % 10) != 0;
      if ($urandom % 20 == 0) blank_i = ~blank_i;
      if ($urandom % 100 == 0) psave_i = ~psave_i;
      if ($urandom % 100 == 0) duty4_i = ~duty4_i;
      if ($urandom % 150 == 0) frame_div_i = 8'($urandom % 4);
      cyc();
    end
    wr_data_i = 0; set_ptr_i = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule